// File: doc/BRIEF.md
# Programmable Divider and Single-Shot Timer

This block is a synchronous timer built on a 16-stage binary counter. The counter runs on the system clock and advances one step on each clock edge where the `tick` qualifier is high, so any slower time base can drive it through `tick`. A two-bit ratio select picks one of four counter stages as the tap. The selected stage n divides the tick rate by 2^n.

Two operating modes are available. In recycle mode the tapped stage drives the output directly, which gives a continuous square wave. In single-cycle mode a one-shot latch is armed by a reset. When the tapped stage first goes high, which is after 2^(n-1) ticks, the latch sets, the output changes level once, and the output then stays put. The latch re-arms only on a reset or on a change of the mode level. A polarity input picks the resting level of the output.

There are two reset sources. The master reset always acts. The power-on pulse acts only when it is not blocked. While either reset is active, the counter is held cleared and ticks are not counted.

Top module: `ptmr_top`

## Requirements
- R1: `ratio_sel` (bit 1 = A, bit 0 = B) picks stage n as follows: 00 gives n=13, 01 gives n=10, 10 gives n=8 and 11 gives n=16. With `recycle`=1 and no reset, the output changes on the clock edge that takes tick number k·2^(n-1), counted from the last clear, for every k of 1 or more. This gives a period of 2^n ticks.
- R2: The counter advances only on clock edges where `tick`=1. Edges with `tick`=0 leave the count and the output unchanged.
- R3: While a reset is active, `tmr_out` equals `inv_sel`. Outside reset, `tmr_out` is the mode's raw level XOR `inv_sel`. Both the raw stage level and the latch are 0 after a clear.
- R4: `mstr_rst` is active high. On each clock edge where it is high, it clears the counter and the one-shot latch, whatever the value of `por_block`.
- R5: `por_pulse` clears the counter and the latch like a reset only when `por_block`=0. When `por_block`=1, the pulse has no effect.
- R6: Ticks presented during reset are not counted. After reset is released, counting starts from zero, so the first output change needs a full 2^(n-1) ticks.
- R7: With `recycle`=0, the output changes level on the edge that takes tick 2^(n-1) after a clear. It then keeps that level for at least 2^n further ticks, until it is re-armed.
- R8: A change in the level of `recycle` clears the counter and the latch on the next clock edge. This re-arms single-cycle operation and restarts recycle counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| tick | input | 1 | Count qualifier; one count per high-sampled edge |
| mstr_rst | input | 1 | Master reset, active high, synchronous |
| por_pulse | input | 1 | Power-on reset pulse from an external detector |
| por_block | input | 1 | 1 = power-on pulse ignored |
| ratio_sel | input | 2 | Tap stage select (bit 1 = A, bit 0 = B) |
| inv_sel | input | 1 | Output polarity; resting level of the output |
| recycle | input | 1 | 1 = continuous divide, 0 = single-cycle timer |
| tmr_out | output | 1 | Timer output |

## Verification
A counter off by even one count moves the first output edge by one tick away from 2^(n-1). That error shows at the port on the edge where the transition was expected, or one edge later. A latch that fails to hold, or that sets too early, shows as an extra or an early output edge within one half-period. A clear that is missed after a reset, a power-on pulse or a mode flip is seen at the first expected transition, up to 2^(n-1) ticks later. The bench compares the output on every cycle, so the first deviating edge is always reported.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int STAGES = 16;

    typedef enum logic [1:0] {
        RATIO_S13 = 2'b00,
        RATIO_S10 = 2'b01,
        RATIO_S8  = 2'b10,
        RATIO_S16 = 2'b11
    } ratio_e;

    typedef enum logic {
        MODE_SINGLE  = 1'b0,
        MODE_RECYCLE = 1'b1
    } mode_e;

    // control word shared between reset logic and datapath
    typedef struct packed {
        logic in_reset;
        logic clear;
        logic advance;
    } ctl_t;

    // stage number (1-based) tapped for each ratio code
    function automatic int tap_stage(input ratio_e r);
        int s;
        unique case (r)
            RATIO_S13: s = 13;
            RATIO_S10: s = 10;
            RATIO_S8:  s = 8;
            default:   s = 16;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ptmr_reset_ctl.sv
module ptmr_reset_ctl (
    input  logic             clk,
    input  logic             mstr_rst,
    input  logic             por_pulse,
    input  logic             por_block,
    input  logic             tick,
    input  ptmr_pkg::mode_e  mode,
    output ptmr_pkg::ctl_t   ctl
);
    import ptmr_pkg::*;

    mode_e mode_q;

    // registered copy of mode; a level difference marks a mode change
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    always_comb begin
        ctl.in_reset = mstr_rst | (por_pulse & ~por_block);
        ctl.clear    = ctl.in_reset | (mode != mode_q);
        ctl.advance  = tick & ~ctl.clear;
    end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int STAGES = ptmr_pkg::STAGES
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              advance,
    output logic [STAGES-1:0] cnt_q,
    output logic [STAGES-1:0] cnt_nxt
);
    logic [STAGES-1:0] carry;

    assign carry[0] = advance;

    // synchronous toggle chain: stage i flips when all lower stages are 1
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign cnt_nxt[i] = cnt_q[i] ^ carry[i];
        if (i < STAGES - 1) begin : g_carry
            assign carry[i+1] = carry[i] & cnt_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (clear) cnt_q <= '0;
        else       cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/ptmr_tap_sel.sv
module ptmr_tap_sel #(
    parameter int STAGES = ptmr_pkg::STAGES
) (
    input  ptmr_pkg::ratio_e  sel,
    input  logic [STAGES-1:0] cnt_q,
    input  logic [STAGES-1:0] cnt_nxt,
    output logic              stage_now,
    output logic              stage_next
);
    localparam int IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx        = IDX_W'(ptmr_pkg::tap_stage(sel) - 1);
        stage_now  = cnt_q[idx];
        stage_next = cnt_nxt[idx];
    end

endmodule

// File: rtl/ptmr_shot_latch.sv
module ptmr_shot_latch (
    input  logic clk,
    input  logic clear,
    input  logic advance,
    input  logic stage_next,
    output logic fired_q
);
    // sets on the same edge that raises the tapped stage, then holds
    always_ff @(posedge clk) begin
        if (clear)                       fired_q <= 1'b0;
        else if (advance && stage_next)  fired_q <= 1'b1;
    end

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
    parameter int STAGES = ptmr_pkg::STAGES
) (
    input  logic       clk,
    input  logic       tick,
    input  logic       mstr_rst,
    input  logic       por_pulse,
    input  logic       por_block,
    input  logic [1:0] ratio_sel,
    input  logic       inv_sel,
    input  logic       recycle,
    output logic       tmr_out
);
    import ptmr_pkg::*;

    ratio_e            sel_e;
    mode_e             mode_e_q;
    ctl_t              ctl;
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_nxt;
    logic              stage_now;
    logic              stage_next;
    logic              fired_q;
    logic              raw_lvl;

    assign sel_e    = ratio_e'(ratio_sel);
    assign mode_e_q = mode_e'(recycle);

    ptmr_reset_ctl u_rst (
        .clk       (clk),
        .mstr_rst  (mstr_rst),
        .por_pulse (por_pulse),
        .por_block (por_block),
        .tick      (tick),
        .mode      (mode_e_q),
        .ctl       (ctl)
    );

    ptmr_counter #(.STAGES(STAGES)) u_cnt (
        .clk     (clk),
        .clear   (ctl.clear),
        .advance (ctl.advance),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    ptmr_tap_sel #(.STAGES(STAGES)) u_tap (
        .sel        (sel_e),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt),
        .stage_now  (stage_now),
        .stage_next (stage_next)
    );

    ptmr_shot_latch u_shot (
        .clk        (clk),
        .clear      (ctl.clear),
        .advance    (ctl.advance),
        .stage_next (stage_next),
        .fired_q    (fired_q)
    );

    assign raw_lvl = (mode_e_q == MODE_RECYCLE) ? stage_now : fired_q;
    assign tmr_out = inv_sel ^ (raw_lvl & ~ctl.in_reset);

endmodule

// File: rtl/ptmr_checks.sv
module ptmr_checks #(
    parameter int STAGES = 16
) (
    input logic              clk,
    input logic              mstr_rst,
    input logic              por_pulse,
    input logic              por_block,
    input logic              tick,
    input logic              recycle,
    input logic [STAGES-1:0] cnt,
    input logic              fired
);
    logic rec_q;
    logic por_hit;
    logic mode_flip;

    always_ff @(posedge clk) rec_q <= recycle;

    assign por_hit   = por_pulse & ~por_block;
    assign mode_flip = recycle != rec_q;

    assert_mstr_clear_R4: assert property (@(posedge clk) disable iff (mstr_rst)
        $fell(mstr_rst) |-> (cnt == '0 && !fired));

    assert_por_clear_R5: assert property (@(posedge clk) disable iff (mstr_rst)
        por_hit |=> (cnt == '0 && !fired));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (mstr_rst)
        (!tick && !por_hit && !mode_flip) |=> $stable(cnt));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (mstr_rst)
        (tick && !por_hit && !mode_flip) |=> cnt == $past(cnt) + 1'b1);

    assert_shot_hold_R7: assert property (@(posedge clk) disable iff (mstr_rst)
        (fired && !recycle && !por_hit && !mode_flip) |=> fired);

    assert_mode_rearm_R8: assert property (@(posedge clk) disable iff (mstr_rst)
        mode_flip |=> (cnt == '0 && !fired));

endmodule

bind ptmr_top ptmr_checks #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .mstr_rst  (mstr_rst),
    .por_pulse (por_pulse),
    .por_block (por_block),
    .tick      (tick),
    .recycle   (recycle),
    .cnt       (cnt_q),
    .fired     (fired_q)
);

// File: tb/ptmr_top_bench.sv
module ptmr_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       tick = 1'b0;
    logic       mstr_rst = 1'b1;
    logic       por_pulse = 1'b0;
    logic       por_block = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       inv_sel = 1'b0;
    logic       recycle = 1'b1;
    logic       tmr_out;

    always #2.5 clk = ~clk;

    ptmr_top u_ptmr_top (
        .clk       (clk),
        .tick      (tick),
        .mstr_rst  (mstr_rst),
        .por_pulse (por_pulse),
        .por_block (por_block),
        .ratio_sel (ratio_sel),
        .inv_sel   (inv_sel),
        .recycle   (recycle),
        .tmr_out   (tmr_out)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    item_t mon_it;
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;

    // next-cycle stimulus, applied at the following falling edge
    logic       b_mrst = 1'b1, b_por = 1'b0, b_blk = 1'b0;
    logic [1:0] b_sel = 2'b00;
    logic       b_inv = 1'b0, b_rec = 1'b1;
    string      tag = "R3";

    // reference state, derived from the requirements
    int   m_ticks = 0;
    bit   m_fired = 0;
    logic m_mode_last = 1'b1;

    function automatic int stage_of(input logic [1:0] s);
        case (s)
            2'b00:   return 13;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    // driver: apply one cycle and push the level expected after the edge
    task automatic step(input logic tk);
        int    n;
        logic  in_rst, clr, raw;
        item_t it;
        @(negedge clk);
        tick = tk; mstr_rst = b_mrst; por_pulse = b_por; por_block = b_blk;
        ratio_sel = b_sel; inv_sel = b_inv; recycle = b_rec;
        n      = stage_of(b_sel);
        in_rst = b_mrst | (b_por & ~b_blk);
        clr    = in_rst | (b_rec != m_mode_last);
        if (clr) begin
            m_ticks = 0; m_fired = 0;
        end else if (tk) begin
            m_ticks++;
            if (((m_ticks >> (n - 1)) & 1) == 1) m_fired = 1;
        end
        m_mode_last = b_rec;
        raw    = b_rec ? logic'((m_ticks >> (n - 1)) & 1) : logic'(m_fired);
        it.exp = in_rst ? b_inv : (raw ^ b_inv);
        it.req = tag;
        q.push_back(it);
    endtask

    task automatic run(input int nt, input logic tk);
        repeat (nt) step(tk);
    endtask

    task automatic do_reset(input int cyc);
        b_mrst = 1'b1;
        run(cyc, 1'b1);
        b_mrst = 1'b0;
    endtask

    // monitor: compare the output after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            mon_it = q.pop_front();
            n_checks++;
            if (tmr_out !== mon_it.exp) begin
                n_fail++;
                $display("FAIL %s: tmr_out=%0b expected %0b at %0t",
                         mon_it.req, tmr_out, mon_it.exp, $time);
            end
        end
    end

    initial begin
        // R3: reset level follows polarity select
        tag = "R3"; b_inv = 1'b0; b_rec = 1'b1;
        do_reset(3);
        b_mrst = 1'b1; b_inv = 1'b1; run(3, 1'b1);

        // R1: recycle mode on every ratio, both polarities
        tag = "R1";
        for (int s = 0; s < 4; s++) begin
            b_sel = 2'(s); b_rec = 1'b1; b_inv = s[0];
            do_reset(2);
            run((1 << stage_of(2'(s))) + 4, 1'b1);
        end

        // R2: sparse ticks on stage 8
        tag = "R2"; b_sel = 2'b10; b_inv = 1'b0;
        do_reset(2);
        for (int i = 0; i < 450; i++) step(i % 3 == 0);
        run(20, 1'b0);

        // R7: single-cycle on every ratio, hold for 2^n further ticks
        tag = "R7";
        for (int s = 0; s < 4; s++) begin
            int n;
            n = stage_of(2'(s));
            b_sel = 2'(s); b_rec = 1'b0; b_inv = ~s[0];
            do_reset(2);
            run((1 << (n - 1)) + ((n < 16) ? (1 << n) : 8), 1'b1);
        end

        // R4: master reset mid-count with power-on blocked
        tag = "R4"; b_sel = 2'b01; b_rec = 1'b1; b_inv = 1'b0;
        do_reset(2);
        run(300, 1'b1);
        b_blk = 1'b1; b_mrst = 1'b1; run(5, 1'b1);
        b_mrst = 1'b0; b_blk = 1'b0;
        // R6: counting restarts from zero after release
        tag = "R6"; run(600, 1'b1);

        // R5: power-on pulse honoured, then ignored when blocked
        tag = "R5"; b_sel = 2'b10;
        do_reset(2);
        run(100, 1'b1);
        b_por = 1'b1; step(1'b1); b_por = 1'b0;
        run(140, 1'b1);
        b_blk = 1'b1; b_por = 1'b1; run(3, 1'b1); b_por = 1'b0;
        run(200, 1'b1);
        b_blk = 1'b0;

        // R8: mode flip re-arms the one-shot
        tag = "R8"; b_rec = 1'b0; b_inv = 1'b1;
        do_reset(2);
        run(200, 1'b1);
        b_rec = 1'b1; run(4, 1'b1);
        b_rec = 1'b0; run(140, 1'b1);
        run(300, 1'b1);

        run(2, 1'b0);
        @(posedge clk); #2;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule